// File: doc/BRIEF.md
# Complementary Pair Dead-Band Generator

This block turns one raw PWM compare signal into a high-side and a low-side drive signal for a complementary transistor pair. It watches the raw signal for transitions. On every transition it switches off the output that was on, loads a 6-bit down counter with a programmable dead-band length, and turns on the other output only when that counter reaches zero. As a result, the two outputs are never on together.

Two dead-band values are supplied. In edge-split assignment, the value used depends on the direction of the transition, so that the high-to-low and low-to-high handovers can be tuned separately. In per-pair assignment, a select input ties the pair to one of the two values, and that value is used for both directions. The counter advances through a prescaler that divides the system clock by 1, 2, 4 or 8. The prescaler restarts on every counter load and on every configuration write strobe.

Top module: `dt_pair_gen`

## Requirements
- R1: While reset is active and after it is released (with the raw input low), `hi_o` is 0 and `lo_o` is 1.
- R2: With `split_mode_i`=1, a rising raw edge keeps both outputs off for `dt_a_i`×prescale cycles, and then `hi_o` goes to 1.
- R3: With `split_mode_i`=1, a falling raw edge keeps both outputs off for `dt_b_i`×prescale cycles, and then `lo_o` goes to 1.
- R4: With `split_mode_i`=0, both edge directions use `dt_a_i` when `pair_sel_i`=0 and `dt_b_i` when `pair_sel_i`=1.
- R5: `presc_sel_i` values 0, 1, 2 and 3 give a prescale of 1, 2, 4 and 8 system cycles per counter step.
- R6: The output that was on turns off at the first clock edge that samples the raw transition. During the dead band, both outputs are 0.
- R7: A selected dead-band value of 0 turns the target output on at the first clock edge that samples the transition.
- R8: A transition that arrives while a count is running reloads the counter with the value for the new direction. The output that was pending never turns on.
- R9: A pulse on `cfg_wr_i` clears the prescaler and leaves the counter unchanged. With prescale 8, a pulse in the fifth cycle of the count stretches the dead band from 16 to 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Raw PWM compare signal |
| dt_a_i | input | 6 | First dead-band value |
| dt_b_i | input | 6 | Second dead-band value |
| presc_sel_i | input | 2 | Prescale select: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| split_mode_i | input | 1 | 1 selects edge-split assignment, 0 selects per-pair assignment |
| pair_sel_i | input | 1 | Value used in per-pair assignment: 0 selects A, 1 selects B |
| cfg_wr_i | input | 1 | Configuration write strobe; clears the prescaler |
| hi_o | output | 1 | High-side drive |
| lo_o | output | 1 | Low-side drive |

## Verification
The bench builds the block with its default parameters: a 6-bit counter and a 2-bit prescale select. These defaults make the full range reachable, up to a 63-step count at divide-by-8, which is 504 dead cycles. Every measured dead band is therefore a count of cycles that can be checked exactly against value × 2^select. This includes the zero-delay case, a retrigger in the middle of a count, and a strobe that restarts the prescaler in the middle of a count.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic {
    ASSIGN_PER_PAIR   = 1'b0,
    ASSIGN_EDGE_SPLIT = 1'b1
  } assign_e;

  // widest prescaler count for a given select width
  function automatic int presc_cnt_w(input int sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/dt_edge_det.sv
module dt_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = dt_pkg::presc_cnt_w(SEL_W);

  logic [CNT_W-1:0] pc_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((32'd1 << sel_i) - 32'd1);
  assign tick_o = run_i && (pc_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (!run_i) pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/dt_down_counter.sv
module dt_down_counter #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [DT_W-1:0] load_val_i,
  input  logic            tick_i,
  output logic            zero_o
);
  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dt_pair_gen.sv
module dt_pair_gen #(
  parameter int DT_W  = 6,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic [DT_W-1:0]  dt_a_i,
  input  logic [DT_W-1:0]  dt_b_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             split_mode_i,
  input  logic             pair_sel_i,
  input  logic             cfg_wr_i,
  output logic             hi_o,
  output logic             lo_o
);
  import dt_pkg::*;

  logic            rise, fall, edge_any;
  logic            tick, zero;
  logic            tgt_q;
  logic [DT_W-1:0] dt_sel;
  assign_e         mode;

  assign mode = assign_e'(split_mode_i);

  dt_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (pwm_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign edge_any = rise | fall;

  always_comb begin
    if (mode == ASSIGN_EDGE_SPLIT) dt_sel = rise ? dt_a_i : dt_b_i;
    else                           dt_sel = pair_sel_i ? dt_b_i : dt_a_i;
  end

  dt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (edge_any | cfg_wr_i),
    .run_i  (~zero),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  dt_down_counter #(.DT_W(DT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (edge_any),
    .load_val_i (dt_sel),
    .tick_i     (tick),
    .zero_o     (zero)
  );

  // level the pair is heading to
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tgt_q <= 1'b0;
    else if (edge_any) tgt_q <= pwm_i;
  end

  assign hi_o = zero &  tgt_q;
  assign lo_o = zero & ~tgt_q;
endmodule

// File: rtl/dt_pair_gen_chk.sv
module dt_pair_gen_chk #(
  parameter int DT_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pwm_i,
  input logic [DT_W-1:0] dt_a_i,
  input logic            split_mode_i,
  input logic            hi_o,
  input logic            lo_o
);
  assert_lo_off_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_i) |=> !lo_o);

  assert_hi_off_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_i) |=> !hi_o);

  assert_hi_on_after_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> $past(pwm_i));

  assert_lo_on_after_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> !$past(pwm_i));

  assert_zero_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_i) && split_mode_i && dt_a_i == '0) |=> hi_o);
endmodule

bind dt_pair_gen dt_pair_gen_chk #(.DT_W(DT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwm_i        (pwm_i),
  .dt_a_i       (dt_a_i),
  .split_mode_i (split_mode_i),
  .hi_o         (hi_o),
  .lo_o         (lo_o)
);

// File: tb/dt_pair_gen_test.sv
module dt_pair_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwm_i = 1'b0;
  logic [5:0] dt_a_i = '0, dt_b_i = '0;
  logic [1:0] presc_sel_i = '0;
  logic       split_mode_i = 1'b1, pair_sel_i = 1'b0, cfg_wr_i = 1'b0;
  logic       hi_o, lo_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  dt_pair_gen uut (.*);

  typedef struct packed {
    logic       split;
    logic       psel;
    logic [1:0] sel;
    logic [5:0] a;
    logic [5:0] b;
    logic       rise;
    logic [9:0] expd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 6'd5,  6'd9,  1'b1, 10'd5},
    '{1'b1, 1'b0, 2'd0, 6'd5,  6'd9,  1'b0, 10'd9},
    '{1'b1, 1'b0, 2'd1, 6'd3,  6'd9,  1'b1, 10'd6},
    '{1'b1, 1'b0, 2'd2, 6'd3,  6'd7,  1'b0, 10'd28},
    '{1'b1, 1'b0, 2'd3, 6'd63, 6'd1,  1'b1, 10'd504},
    '{1'b1, 1'b0, 2'd3, 6'd2,  6'd1,  1'b0, 10'd8},
    '{1'b0, 1'b0, 2'd0, 6'd4,  6'd11, 1'b1, 10'd4},
    '{1'b0, 1'b0, 2'd0, 6'd4,  6'd11, 1'b0, 10'd4},
    '{1'b0, 1'b1, 2'd0, 6'd4,  6'd11, 1'b1, 10'd11},
    '{1'b0, 1'b1, 2'd1, 6'd4,  6'd11, 1'b0, 10'd22},
    '{1'b1, 1'b0, 2'd0, 6'd0,  6'd9,  1'b1, 10'd0},
    '{1'b0, 1'b1, 2'd2, 6'd5,  6'd0,  1'b0, 10'd0},
    '{1'b1, 1'b0, 2'd1, 6'd0,  6'd5,  1'b0, 10'd10}
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cycle();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic configure(input vec_t v);
    split_mode_i = v.split;
    pair_sel_i   = v.psel;
    presc_sel_i  = v.sel;
    dt_a_i       = v.a;
    dt_b_i       = v.b;
    cfg_wr_i     = 1'b1;
    cycle();
    cfg_wr_i     = 1'b0;
  endtask

  task automatic settle(input logic lvl);
    pwm_i = lvl;
    repeat (600) cycle();
  endtask

  // returns k: clock edges after the edge until the target output is on
  task automatic run_edge(input logic rise, output int k, output bit other_on);
    bit on = 1'b0;
    k = 0;
    other_on = 1'b0;
    pwm_i = rise;
    while (!on && k < 700) begin
      cycle();
      k++;
      if (rise ? lo_o : hi_o) other_on = 1'b1;
      if (rise ? hi_o : lo_o) on = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    bit oth;
    vec_t v;
    @(negedge clk_i);
    check(hi_o == 1'b0 && lo_o == 1'b1, "R1 in reset", {hi_o, lo_o}, 1);
    repeat (2) cycle();
    rst_ni = 1'b1;
    cycle();
    check(hi_o == 1'b0 && lo_o == 1'b1, "R1 after reset", {hi_o, lo_o}, 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      v = VECS[i];
      configure(v);
      settle(!v.rise);
      run_edge(v.rise, k, oth);
      if (v.expd == 0)  tag = "R7 zero value";
      else if (v.split) tag = v.rise ? "R2 rise uses A" : "R3 fall uses B";
      else              tag = "R4 per-pair value";
      if (v.sel != 0) tag = {tag, " with R5 prescale"};
      check(k - 1 == int'(v.expd), tag, k - 1, int'(v.expd));
      check(!oth, "R6 opposite output off", oth, 0);
    end

    // R8: a fall in the middle of a count reloads with B; high never turns on
    begin
      vec_t rv = '{1'b1, 1'b0, 2'd0, 6'd10, 6'd6, 1'b1, 10'd0};
      bit hi_seen = 1'b0, both_off = 1'b1;
      configure(rv);
      settle(1'b0);
      pwm_i = 1'b1;
      repeat (3) begin
        cycle();
        if (hi_o || lo_o) both_off = 1'b0;
      end
      check(both_off, "R6 both off during dead band", both_off, 1);
      pwm_i = 1'b0;
      k = 0;
      while (!lo_o && k < 100) begin
        cycle();
        k++;
        if (hi_o) hi_seen = 1'b1;
      end
      check(k == 7, "R8 reload with new direction", k - 1, 6);
      check(!hi_seen, "R8 pending output stays off", hi_seen, 0);
    end

    // R9: strobe in fifth cycle of a /8 count of 2 delays by 4 cycles
    begin
      vec_t cv = '{1'b1, 1'b0, 2'd3, 6'd2, 6'd1, 1'b1, 10'd0};
      configure(cv);
      settle(1'b0);
      pwm_i = 1'b1;
      repeat (4) cycle();
      cfg_wr_i = 1'b1;
      cycle();
      cfg_wr_i = 1'b0;
      k = 5;
      while (!hi_o && k < 100) begin
        cycle();
        k++;
      end
      check(k == 21, "R9 write clears prescaler", k - 1, 20);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule